// File: doc/BRIEF.md
# Streaming Modular Coefficient Adder/Subtractor

This block takes a stream of coefficient pairs and returns, for each pair, either the sum or the difference reduced modulo a fixed prime Q. It accepts at most one pair per clock and stores no coefficients, so a polynomial is simply a run of beats, index 0 first and the last index last. A one-bit operation select travels with each pair, so additions and subtractions can be mixed from beat to beat.

Both sides use a valid/ready handshake. The result goes into one output register. That register holds its contents while the downstream side is not ready, and the upstream ready signal follows it. The modular correction is a single conditional subtract of Q for addition, or a single conditional add of Q for subtraction. This is enough because operands arrive already reduced.

Top module: `coef_addsub_stream`

## Requirements
- R1: With `in_mode` = 0 the accepted pair (a, b) yields (a + b) mod Q.
- R2: With `in_mode` = 1 the accepted pair (a, b) yields (a − b) mod Q, wrapping to a + Q − b when a < b.
- R3: For operands in 0..Q−1, every presented `out_coef` lies in 0..Q−1.
- R4: A pair accepted while the output register is free gives `out_valid` = 1 with its result after exactly one rising edge.
- R5: `in_ready` is 1 when the output register is empty or `out_ready` is 1, and 0 when `out_valid` = 1 and `out_ready` = 0.
- R6: While `out_valid` = 1 and `out_ready` = 0, `out_valid` and `out_coef` keep their values at the next edge.
- R7: A synchronous active-high `rst` clears `out_valid` at the edge where it is sampled, even with a result pending.
- R8: The operation is taken from `in_mode` of each accepted beat, so alternating modes give alternating operations with no bubble.
- R9: With `out_ready` held at 1, a new pair is accepted every cycle.
- R10: Boundary pairs reduce exactly: a + b = Q gives 0, a = b in subtraction gives 0, a = 0 in subtraction gives Q − b, and (Q−1) + (Q−1) gives Q − 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Block can take a pair this cycle |
| in_mode | input | 1 | 0 = add, 1 = subtract |
| in_a | input | W (12) | First operand, reduced |
| in_b | input | W (12) | Second operand, reduced |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Downstream takes the result this cycle |
| out_coef | output | W (12) | Reduced result |

## Verification
The range assertion and the range requirement both rely on the operands already lying in 0..Q−1. The block has an assertion on that input condition, because a single correction step cannot bring an unreduced operand back into range. The stimulus draws random operands only from 0..Q−1 and adds directed pairs at the range edges (0, Q−1, and pairs that sum to Q). It also holds `in_valid` steady until a pair is accepted, and drives `out_ready` randomly in the stalled phases, which lets the hold assertion see long stalls.

// File: rtl/modq_pkg.sv
package modq_pkg;
  typedef enum logic {OP_ADD = 1'b0, OP_SUB = 1'b1} op_e;
endpackage

// File: rtl/modq_add.sv
module modq_add #(
  parameter int W = 12,
  parameter int Q = 3329
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] r
);
  localparam logic [W:0] QX = (W+1)'(Q);
  logic [W:0] sum;
  logic [W:0] sum_m;
  always_comb begin
    sum   = {1'b0, a} + {1'b0, b};
    sum_m = sum - QX;
    r     = (sum >= QX) ? sum_m[W-1:0] : sum[W-1:0];
  end
endmodule

// File: rtl/modq_sub.sv
module modq_sub #(
  parameter int W = 12,
  parameter int Q = 3329
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] r
);
  localparam logic [W:0] QX = (W+1)'(Q);
  logic [W:0] diff;
  logic [W:0] diff_p;
  always_comb begin
    diff   = {1'b0, a} - {1'b0, b};
    diff_p = diff + QX;
    r      = (a < b) ? diff_p[W-1:0] : diff[W-1:0];
  end
endmodule

// File: rtl/coef_reg_stage.sv
module coef_reg_stage #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);
  logic take;
  assign up_ready = !dn_valid || dn_ready;
  assign take     = up_valid && up_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      dn_valid <= 1'b0;
    end else if (take) begin
      dn_valid <= 1'b1;
    end else if (dn_ready) begin
      dn_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take) dn_data <= up_data;
  end

  assert_accept_lat_R4: assert property (@(posedge clk) disable iff (rst)
    take |=> dn_valid);

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_data)));

  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;
  always_ff @(posedge clk) begin
    if (rst_q) assert_rst_clear_R7: assert (!dn_valid);
  end
endmodule

// File: rtl/coef_addsub_stream.sv
module coef_addsub_stream #(
  parameter int W = 12,
  parameter int Q = 3329
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic         in_mode,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_coef
);
  import modq_pkg::*;
  localparam logic [W-1:0] QW = W'(Q);

  logic [W-1:0] r_add, r_sub, r_sel;
  op_e          op;

  assign op = op_e'(in_mode);

  modq_add #(.W(W), .Q(Q)) u_add (.a(in_a), .b(in_b), .r(r_add));
  modq_sub #(.W(W), .Q(Q)) u_sub (.a(in_a), .b(in_b), .r(r_sub));

  always_comb begin
    case (op)
      OP_SUB:  r_sel = r_sub;
      default: r_sel = r_add;
    endcase
  end

  coef_reg_stage #(.W(W)) u_stage (
    .clk      (clk),
    .rst      (rst),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (r_sel),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (out_coef)
  );

  assert_in_reduced_R3: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> (in_a < QW && in_b < QW));

  assert_out_range_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_coef < QW));
endmodule

// File: tb/sim_coef_addsub_stream.sv
`timescale 1ns/100ps
module sim_coef_addsub_stream;
  localparam int W = 12;
  localparam int Q = 3329;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_mode = 1'b0;
  logic [W-1:0] in_a = '0;
  logic [W-1:0] in_b = '0;
  logic out_ready = 1'b0;
  logic in_ready, out_valid;
  logic [W-1:0] out_coef;

  int checks = 0;
  int fails = 0;
  bit stall_en = 1'b0;
  bit mon_en = 1'b0;
  int exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  coef_addsub_stream #(.W(W), .Q(Q)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
    .out_ready(out_ready), .out_coef(out_coef));

  function automatic int model(bit m, int a, int b);
    if (m) return (a >= b) ? a - b : a + Q - b;
    return (a + b >= Q) ? a + b - Q : a + b;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit rnd_ready();
    return stall_en ? ($urandom_range(2) != 0) : 1'b1;
  endfunction

  // driver: push expected result when the pair is accepted
  task automatic send(bit m, int a, int b, string tag);
    @(negedge clk);
    in_valid = 1'b1; in_mode = m; in_a = W'(a); in_b = W'(b);
    out_ready = rnd_ready();
    #1;
    if (!stall_en) check(in_ready == 1'b1, "R9", int'(in_ready), 1);
    while (!in_ready) begin
      @(negedge clk);
      out_ready = rnd_ready();
      #1;
    end
    exp_q.push_back(model(m, a, b));
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = rnd_ready();
    #1;
  endtask

  task automatic drain();
    while (exp_q.size() > 0) begin
      @(negedge clk);
      in_valid = 1'b0;
      out_ready = 1'b1;
      #1;
    end
  endtask

  // monitor: pops and compares on each output handshake
  bit prev_stall = 1'b0;
  int prev_coef = 0;
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (mon_en) begin
        if (prev_stall) begin
          check(out_valid == 1'b1, "R6 valid", int'(out_valid), 1);
          check(int'(out_coef) == prev_coef, "R6 data", int'(out_coef), prev_coef);
        end
        if (out_valid && !out_ready)
          check(in_ready == 1'b0, "R5 full", int'(in_ready), 0);
        if (!out_valid)
          check(in_ready == 1'b1, "R5 empty", int'(in_ready), 1);
        if (out_valid) check(int'(out_coef) < Q, "R3", int'(out_coef), Q - 1);
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R4 unexpected", int'(out_coef), -1);
          end else begin
            int e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(int'(out_coef) == e, t, int'(out_coef), e);
          end
        end
        prev_stall = out_valid && !out_ready;
        prev_coef = int'(out_coef);
      end else begin
        prev_stall = 1'b0;
      end
    end
  end

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check(out_valid == 1'b0, "R7 reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R5 reset", int'(in_ready), 1);
    mon_en = 1'b1;

    // R4: single beat latency
    send(1'b0, 100, 200, "R1");
    idle();
    check(out_valid == 1'b1, "R4 latency", int'(out_valid), 1);
    check(int'(out_coef) == 300, "R4 data", int'(out_coef), 300);
    drain();

    // R10: boundary pairs, full rate
    send(1'b0, 1, Q - 1, "R10 sum=Q");
    send(1'b0, Q - 1, 1, "R10 sum=Q");
    send(1'b0, 1664, 1665, "R10 sum=Q");
    send(1'b0, 0, 5, "R10 a=0 add");
    send(1'b1, 0, 5, "R10 a=0 sub");
    send(1'b1, 0, 0, "R10 zero");
    send(1'b0, Q - 1, Q - 1, "R10 b=Q-1 add");
    send(1'b1, 0, Q - 1, "R10 b=Q-1 sub");
    send(1'b1, Q - 1, Q - 1, "R10 a=b");
    send(1'b1, 777, 777, "R10 a=b");
    drain();

    // R9 + R8: 256-beat polynomial, alternating modes, no stalls
    for (int i = 0; i < 256; i++)
      send(i[0], $urandom_range(Q - 1), $urandom_range(Q - 1), "R8");
    drain();

    // R1/R2 under random backpressure
    stall_en = 1'b1;
    for (int i = 0; i < 256; i++)
      send(1'b0, $urandom_range(Q - 1), $urandom_range(Q - 1), "R1");
    for (int i = 0; i < 256; i++)
      send(1'b1, $urandom_range(Q - 1), $urandom_range(Q - 1), "R2");
    for (int i = 0; i < 256; i++) begin
      if ($urandom_range(3) == 0) idle();
      send($urandom_range(1) == 1, $urandom_range(Q - 1), $urandom_range(Q - 1), "R8 mixed");
    end
    stall_en = 1'b0;
    drain();

    // R7: reset with a result pending under stall
    mon_en = 1'b0;
    @(negedge clk);
    in_valid = 1'b1; in_mode = 1'b0; in_a = 12'd3; in_b = 12'd4; out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    check(out_valid == 1'b1, "R7 pending", int'(out_valid), 1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(out_valid == 1'b0, "R7 mid-run", int'(out_valid), 0);
    exp_q.delete();
    tag_q.delete();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule